// File: doc/BRIEF.md
# Delay-Slot Load Hazard Classifier

This block sits beside the branch logic of a five-stage integer core. When a taken branch carries a load in its delay slot, the core must know how the first instruction at the branch target treats the load's destination register. That instruction may read it, overwrite it, do both, or ignore it. The block takes the register index and the target instruction word and returns a two-bit use class. The core then picks between stalling, forwarding or dropping the late load result.

The decode is combinational. It is split into field comparison and a per-group rule table, and each rule group has its own priority order. One output register follows the decode and is wrapped in a valid/ready handshake. The upstream side offers a request with `in_valid`, and the block accepts it in any cycle where `in_ready` is high. `in_ready` is high whenever the output register is empty, or is being drained in the same cycle (`out_ready` high). When the downstream side holds `out_ready` low, the held class and `out_valid` stay frozen and `in_ready` drops, so nothing is lost or overwritten.

Top module: `slot_load_use_classifier`

## Requirements
- R1: An accepted request (`in_valid` and `in_ready` both high at a clock edge) appears on `out_class` with `out_valid` high after that edge. With `out_ready` high and no new request, `out_valid` falls after the next edge. Class codes: 0 no use, 1 read and write, 2 read only, 3 write only.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_class` keep their values.
- R3: An instruction word of all zeros gives class 0 for every register index, including index 0.
- R4: Field positions are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. For opcode 0 with funct 0x00, 0x02 or 0x03, the rules apply in this order: rd and rt both equal to the index gives 1; else an rt match gives 2; else an rd match gives 3; else 0.
- R5: For opcode 0 with funct 0x04, 0x06, 0x07, 0x20 to 0x27, 0x2A or 0x2B, the rules apply in this order: rd matches together with rs or rt gives 1; else an rs or rt match gives 2; else an rd match gives 3; else 0.
- R6: Under opcode 0, funct 0x10 and 0x12 give 3 on an rd match. Funct 0x11 and 0x13 give 2 on an rs match. Funct 0x18 to 0x1B give 2 on an rs or rt match. Any other match in these cases gives 0.
- R7: Opcode 0x01 with the rt field equal to 0x00, 0x02, 0x10 or 0x12 gives 2 on an rs match. Other rt codes give 0. Opcodes 0x06 and 0x07 give 2 on an rs match only. Opcodes 0x04 and 0x05 give 2 on an rs or rt match.
- R8: Opcode 0x03 gives 3 exactly when the index equals the link register index (parameter, 31 by default), and 0 otherwise.
- R9: For opcodes 0x08 to 0x0E, 0x20, 0x21, 0x23, 0x24 and 0x25, the rules apply in this order: rt and rs both equal gives 1; else an rs match gives 2; else an rt match gives 3; else 0.
- R10: Opcodes 0x22 and 0x26 give 3 on an rt match. Failing that, they give 2 on an rs match.
- R11: Opcodes 0x28, 0x29, 0x2A, 0x2B and 0x2E give 2 on an rs or rt match. Opcodes 0x32 and 0x3A give 2 on an rs match only.
- R12: Every opcode, funct or branch subcode not named above gives 0. This includes opcode 0x02, opcode 0x0F and funct 0x0C.
- R13: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_idx | input | IDX_W (5) | Destination register of the delay-slot load |
| in_word | input | WORD_W (32) | Instruction word at the branch target |
| out_ready | input | 1 | Downstream takes the class |
| out_valid | output | 1 | Class held on `out_class` is valid |
| out_class | output | 2 | Use class: 0 none, 1 read/write, 2 read, 3 write |

## Verification
The bench builds the block with its defaults: a 5-bit index, a 32-bit word and link index 31. With these values every one of the 32 indices can be drawn, so the random phase reaches index 0 against all-zero fields and index 31 against the link rule. A random back-pressure pattern on `out_ready` exercises acceptance while full, draining and holding. A behavioural reference in the bench predicts the class for every opcode group, the unlisted encodings and each priority tier.

// File: rtl/slot_use_pkg.sv
package slot_use_pkg;

  localparam int OPC_W  = 6;
  localparam int FUNC_W = 6;
  localparam int CLS_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    USE_NONE  = 2'd0,
    USE_BOTH  = 2'd1,
    USE_READ  = 2'd2,
    USE_WRITE = 2'd3
  } use_class_e;

  // three-level priority: combined use, then source use, then destination use
  function automatic use_class_e tier3(input logic both, input logic src, input logic dst);
    if (both)     return USE_BOTH;
    else if (src) return USE_READ;
    else if (dst) return USE_WRITE;
    else          return USE_NONE;
  endfunction

  function automatic use_class_e when_read(input logic hit);
    return hit ? USE_READ : USE_NONE;
  endfunction

endpackage

// File: rtl/slot_field_match.sv
module slot_field_match
  import slot_use_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int WORD_W   = 32,
  parameter int LINK_IDX = 31
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] word,
  output logic [OPC_W-1:0]  opcode,
  output logic [FUNC_W-1:0] funct,
  output logic [IDX_W-1:0]  sub_code,
  output logic              hit_rs,
  output logic              hit_rt,
  output logic              hit_rd,
  output logic              hit_link,
  output logic              word_zero
);

  localparam int OPC_LSB = WORD_W - OPC_W;
  localparam int RS_LSB  = OPC_LSB - IDX_W;
  localparam int NFIELD  = 3;

  logic [NFIELD-1:0] hits;

  // fields rs, rt, rd sit back to back below the opcode
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    localparam int LSB = RS_LSB - g * IDX_W;
    assign hits[g] = (word[LSB +: IDX_W] == idx);
  end

  assign opcode    = word[OPC_LSB +: OPC_W];
  assign funct     = word[FUNC_W-1:0];
  assign sub_code  = word[RS_LSB - IDX_W +: IDX_W];
  assign hit_rs    = hits[0];
  assign hit_rt    = hits[1];
  assign hit_rd    = hits[2];
  assign hit_link  = (idx == IDX_W'(LINK_IDX));
  assign word_zero = ~|word;

endmodule

// File: rtl/slot_rule_table.sv
module slot_rule_table
  import slot_use_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FUNC_W-1:0] funct,
  input  logic [IDX_W-1:0]  sub_code,
  input  logic              hit_rs,
  input  logic              hit_rt,
  input  logic              hit_rd,
  input  logic              hit_link,
  input  logic              word_zero,
  output use_class_e        cls
);

  logic any_src;
  logic regimm_branch;
  use_class_e special_cls;

  assign any_src = hit_rs | hit_rt;
  assign regimm_branch = (sub_code == IDX_W'(5'h00)) || (sub_code == IDX_W'(5'h02)) ||
                         (sub_code == IDX_W'(5'h10)) || (sub_code == IDX_W'(5'h12));

  // register-format group, selected by funct
  always_comb begin
    special_cls = USE_NONE;
    case (funct)
      6'h00, 6'h02, 6'h03:
        special_cls = tier3(hit_rd & hit_rt, hit_rt, hit_rd);
      6'h04, 6'h06, 6'h07,
      6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
      6'h2A, 6'h2B:
        special_cls = tier3(hit_rd & any_src, any_src, hit_rd);
      6'h10, 6'h12:
        special_cls = hit_rd ? USE_WRITE : USE_NONE;
      6'h11, 6'h13:
        special_cls = when_read(hit_rs);
      6'h18, 6'h19, 6'h1A, 6'h1B:
        special_cls = when_read(any_src);
      default:
        special_cls = USE_NONE;
    endcase
  end

  // primary opcode groups
  always_comb begin
    cls = USE_NONE;
    if (!word_zero) begin
      case (opcode)
        6'h00: cls = special_cls;
        6'h01: cls = when_read(hit_rs & regimm_branch);
        6'h03: cls = hit_link ? USE_WRITE : USE_NONE;
        6'h04, 6'h05: cls = when_read(any_src);
        6'h06, 6'h07: cls = when_read(hit_rs);
        6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E,
        6'h20, 6'h21, 6'h23, 6'h24, 6'h25:
          cls = tier3(hit_rt & hit_rs, hit_rs, hit_rt);
        6'h22, 6'h26:
          cls = hit_rt ? USE_WRITE : when_read(hit_rs);
        6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E:
          cls = when_read(any_src);
        6'h32, 6'h3A:
          cls = when_read(hit_rs);
        default: cls = USE_NONE;
      endcase
    end
  end

endmodule

// File: rtl/slot_out_stage.sv
module slot_out_stage #(
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready  = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_valid && in_ready) begin
      valid_q <= 1'b1;
      data_q  <= in_data;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_load_use_classifier.sv
module slot_load_use_classifier
  import slot_use_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int WORD_W   = 32,
  parameter int LINK_IDX = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [WORD_W-1:0] in_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CLS_W-1:0]  out_class
);

  logic [OPC_W-1:0]  opcode;
  logic [FUNC_W-1:0] funct;
  logic [IDX_W-1:0]  sub_code;
  logic              hit_rs, hit_rt, hit_rd, hit_link, word_zero;
  use_class_e        cls;

  slot_field_match #(
    .IDX_W(IDX_W), .WORD_W(WORD_W), .LINK_IDX(LINK_IDX)
  ) u_match (
    .idx(in_idx), .word(in_word),
    .opcode(opcode), .funct(funct), .sub_code(sub_code),
    .hit_rs(hit_rs), .hit_rt(hit_rt), .hit_rd(hit_rd),
    .hit_link(hit_link), .word_zero(word_zero)
  );

  slot_rule_table #(.IDX_W(IDX_W)) u_rules (
    .opcode(opcode), .funct(funct), .sub_code(sub_code),
    .hit_rs(hit_rs), .hit_rt(hit_rt), .hit_rd(hit_rd),
    .hit_link(hit_link), .word_zero(word_zero), .cls(cls)
  );

  slot_out_stage #(.DATA_W(CLS_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(CLS_W'(cls)),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_class)
  );

endmodule

// File: rtl/slot_load_use_classifier_chk.sv
module slot_load_use_classifier_chk #(
  parameter int IDX_W    = 5,
  parameter int WORD_W   = 32,
  parameter int LINK_IDX = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IDX_W-1:0]  in_idx,
  input logic [WORD_W-1:0] in_word,
  input logic              out_ready,
  input logic              out_valid,
  input logic [1:0]        out_class
);

  localparam int OPC_LSB = WORD_W - 6;
  localparam int RT_LSB  = OPC_LSB - 2 * IDX_W;

  logic take;
  assign take = in_valid && in_ready;

  // R1: accepted request shows up valid after the edge
  p_accept_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R2: stalled output is frozen and intake closed
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_class)));

  p_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3: all-zero word never reports a use
  p_zero_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_word == '0) |=> (out_class == 2'd0));

  // R8: link write reported for the link register
  p_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_word[OPC_LSB +: 6] == 6'h03 && in_idx == IDX_W'(LINK_IDX)) |=> (out_class == 2'd3));

  // R11: full-word store reads its data register
  p_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_word[OPC_LSB +: 6] == 6'h2B && in_word[RT_LSB +: IDX_W] == in_idx) |=> (out_class == 2'd2));

  // R12: plain jump never uses a register
  p_plain_jump_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_word[OPC_LSB +: 6] == 6'h02) |=> (out_class == 2'd0));

endmodule

bind slot_load_use_classifier slot_load_use_classifier_chk #(
  .IDX_W(IDX_W), .WORD_W(WORD_W), .LINK_IDX(LINK_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_idx(in_idx), .in_word(in_word), .out_ready(out_ready),
  .out_valid(out_valid), .out_class(out_class)
);

// File: tb/slot_load_use_classifier_test.sv
`timescale 1ns/1ps
module slot_load_use_classifier_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_idx = '0;
  logic [31:0] in_word = '0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [1:0]  out_class;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  slot_load_use_classifier uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_word(in_word), .out_ready(out_ready),
    .out_valid(out_valid), .out_class(out_class)
  );

  function automatic logic [31:0] rword(int op, int s, int t, int d, int fn);
    return {op[5:0], s[4:0], t[4:0], d[4:0], 5'd0, fn[5:0]};
  endfunction

  // behavioural reference for the class codes
  function automatic int ref_class(int r, logic [31:0] w);
    int op = int'(w[31:26]);
    int fn = int'(w[5:0]);
    bit s = (int'(w[25:21]) == r);
    bit t = (int'(w[20:16]) == r);
    bit d = (int'(w[15:11]) == r);
    if (w == 32'd0) return 0;
    if (op == 0) begin
      if (fn inside {0, 2, 3}) return (d && t) ? 1 : t ? 2 : d ? 3 : 0;
      if (fn inside {4, 6, 7, [32:39], 42, 43}) return (d && (s || t)) ? 1 : (s || t) ? 2 : d ? 3 : 0;
      if (fn inside {16, 18}) return d ? 3 : 0;
      if (fn inside {17, 19}) return s ? 2 : 0;
      if (fn inside {[24:27]}) return (s || t) ? 2 : 0;
      return 0;
    end
    if (op == 1) return (s && (int'(w[20:16]) inside {0, 2, 16, 18})) ? 2 : 0;
    if (op == 3) return (r == 31) ? 3 : 0;
    if (op inside {4, 5}) return (s || t) ? 2 : 0;
    if (op inside {6, 7}) return s ? 2 : 0;
    if (op inside {[8:14], 32, 33, 35, 36, 37}) return (s && t) ? 1 : s ? 2 : t ? 3 : 0;
    if (op inside {34, 38}) return t ? 3 : s ? 2 : 0;
    if (op inside {40, 41, 42, 43, 46}) return (s || t) ? 2 : 0;
    if (op inside {50, 58}) return s ? 2 : 0;
    return 0;
  endfunction

  function automatic string tag_of(logic [31:0] w);
    int op = int'(w[31:26]);
    int fn = int'(w[5:0]);
    if (w == 32'd0) return "R3";
    if (op == 0) begin
      if (fn inside {0, 2, 3}) return "R4";
      if (fn inside {4, 6, 7, [32:39], 42, 43}) return "R5";
      if (fn inside {[16:19], [24:27]}) return "R6";
      return "R12";
    end
    if (op inside {1, 4, 5, 6, 7}) return "R7";
    if (op == 3) return "R8";
    if (op inside {[8:14], 32, 33, 35, 36, 37}) return "R9";
    if (op inside {34, 38}) return "R10";
    if (op inside {40, 41, 42, 43, 46, 50, 58}) return "R11";
    return "R12";
  endfunction

  // cycle model of the output register
  bit    m_valid = 1'b0;
  int    m_class = 0;
  string m_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_valid <= 1'b1;
      m_class <= ref_class(int'(in_idx), in_word);
      m_tag   <= tag_of(in_word);
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the edge
  always @(negedge clk) begin
    if (live && rst_n) begin
      check(out_valid == m_valid, "R1", int'(out_valid), int'(m_valid));
      check(in_ready == (!m_valid || out_ready), "R2", int'(in_ready), int'(!m_valid || out_ready));
      if (m_valid) check(int'(out_class) == m_class, m_tag, int'(out_class), m_class);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic put(int r, logic [31:0] w, int exp, string req);
    @(posedge clk); #1;
    in_valid = 1'b1; in_idx = r[4:0]; in_word = w; out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(out_valid && int'(out_class) == exp, req, int'(out_class), exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && in_ready, "R13", int'(out_valid), 0);
    rst_n = 1'b1;
    live  = 1'b1;

    // R3
    put(0, 32'd0, 0, "R3");
    put(9, 32'd0, 0, "R3");
    // R4 constant shifts
    put(9, rword(0, 0, 9, 9, 2), 1, "R4");
    put(9, rword(0, 0, 9, 3, 0), 2, "R4");
    put(9, rword(0, 0, 4, 9, 3), 3, "R4");
    put(9, rword(0, 9, 1, 2, 0), 0, "R4");
    // R5 register ALU and variable shifts
    put(9, rword(0, 9, 2, 9, 32), 1, "R5");
    put(9, rword(0, 1, 9, 1, 35), 2, "R5");
    put(9, rword(0, 1, 2, 9, 43), 3, "R5");
    put(9, rword(0, 1, 9, 9, 4), 1, "R5");
    put(9, rword(0, 1, 2, 3, 39), 0, "R5");
    // R6 HI/LO and multiply/divide
    put(9, rword(0, 0, 0, 9, 16), 3, "R6");
    put(9, rword(0, 9, 0, 0, 19), 2, "R6");
    put(9, rword(0, 0, 0, 9, 19), 0, "R6");
    put(9, rword(0, 1, 9, 0, 25), 2, "R6");
    put(9, rword(0, 1, 2, 9, 26), 0, "R6");
    // R7 branches
    put(9, {6'h01, 5'd9, 5'h10, 16'h0040}, 2, "R7");
    put(9, {6'h01, 5'd9, 5'h01, 16'h0040}, 0, "R7");
    put(9, {6'h04, 5'd3, 5'd9, 16'h0010}, 2, "R7");
    put(9, {6'h07, 5'd3, 5'd9, 16'h0010}, 0, "R7");
    put(9, {6'h06, 5'd9, 5'd0, 16'h0010}, 2, "R7");
    // R8 link
    put(31, {6'h03, 26'h0000123}, 3, "R8");
    put(9, {6'h03, 5'd9, 5'd9, 16'h0123}, 0, "R8");
    // R9 immediate ALU and ordinary loads
    put(9, {6'h09, 5'd9, 5'd9, 16'h0004}, 1, "R9");
    put(9, {6'h0D, 5'd9, 5'd2, 16'h0004}, 2, "R9");
    put(9, {6'h23, 5'd2, 5'd9, 16'h0004}, 3, "R9");
    put(9, {6'h24, 5'd9, 5'd9, 16'h0004}, 1, "R9");
    // R10 partial-word loads
    put(9, {6'h22, 5'd9, 5'd9, 16'h0001}, 3, "R10");
    put(9, {6'h26, 5'd9, 5'd1, 16'h0001}, 2, "R10");
    // R11 stores and coprocessor-2 transfers
    put(9, {6'h2B, 5'd1, 5'd9, 16'h0008}, 2, "R11");
    put(9, {6'h29, 5'd9, 5'd1, 16'h0008}, 2, "R11");
    put(9, {6'h2E, 5'd9, 5'd9, 16'h0008}, 2, "R11");
    put(9, {6'h32, 5'd1, 5'd9, 16'h0008}, 0, "R11");
    put(9, {6'h3A, 5'd9, 5'd1, 16'h0008}, 2, "R11");
    // R12 unlisted encodings
    put(9, {6'h02, 5'd9, 5'd9, 5'd9, 11'd0}, 0, "R12");
    put(9, rword(0, 9, 9, 9, 12), 0, "R12");
    put(9, {6'h0F, 5'd9, 5'd9, 16'hFFFF}, 0, "R12");
    put(9, {6'h27, 5'd9, 5'd9, 16'h0000}, 0, "R12");

    // R2 / R1 back-pressure sequence
    @(posedge clk); #1;
    in_valid = 1'b1; in_idx = 5'd9; in_word = rword(0, 9, 2, 9, 32); out_ready = 1'b0;
    @(posedge clk); #1;
    in_word = {6'h23, 5'd2, 5'd9, 16'h0004};
    check(out_valid && !in_ready && out_class == 2'd1, "R2", int'(out_class), 1);
    @(posedge clk); #1;
    check(out_valid && !in_ready && out_class == 2'd1, "R2", int'(out_class), 1);
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(out_valid && out_class == 2'd3, "R1", int'(out_class), 3);
    @(posedge clk); #1;
    check(!out_valid, "R1", int'(out_valid), 0);

    // random traffic under random back-pressure, compared by the model
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      begin
        int r = $urandom_range(31);
        int op = ($urandom_range(1) == 1) ? 0 : $urandom_range(63);
        int s = ($urandom_range(1) == 1) ? r : $urandom_range(31);
        int t = ($urandom_range(1) == 1) ? r : $urandom_range(31);
        int d = ($urandom_range(1) == 1) ? r : $urandom_range(31);
        int fn = $urandom_range(63);
        in_valid  = ($urandom_range(3) != 0);
        out_ready = ($urandom_range(2) != 0);
        in_idx    = r[4:0];
        in_word   = ($urandom_range(15) == 0) ? 32'd0 : rword(op, s, t, d, fn);
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule